// File: doc/BRIEF.md
# Transmit Completion Event Coalescer

This block decides when a transmit queue should get a status update. Every finished transmit buffer transfer pulses a completion strobe for its queue, and a per-queue counter keeps track of completions that have not yet been reported. An update pulse is issued when one of three things happens:

- the pending count reaches a programmed count limit;
- a tick timer, which runs only while completions are pending, reaches a programmed tick limit;
- another event source requests an update for that queue.

Each queue has its own count limit, tick limit, counter and timer. A write port sets the limits.

An update always reports the current transmit progress, whatever caused it. So every update clears the pending counter and the timer. A limit of zero turns its trigger off. With the count trigger off and the timer on, the timer alone bounds how long a completion can wait. Both limits come out of reset at zero.

Top module: `txc_coalescer`

## Requirements
- R1: After reset every limit register is zero, every counter is empty and `updPulse` is low.
- R2: Each completion strobe adds one to its queue's pending count. When the count reaches a nonzero count limit, a one-cycle `updPulse` follows. It appears two cycles after the cycle that sampled the completing strobe.
- R3: With a count limit of one, every completion strobe produces its own update pulse two cycles later, including strobes on consecutive cycles.
- R4: A count limit of zero disables the count trigger. With both limits at zero and no external request, no number of completions produces a pulse.
- R5: An external request produces a pulse one cycle later and clears that queue's pending count. A later count trigger then needs a full count limit of fresh completions.
- R6: With a nonzero tick limit T, the timer starts at zero on the cycle after the first pending completion is counted. A pulse appears T+2 cycles after that first strobe. Later strobes do not restart the timer, and a tick limit of zero disables the timer.
- R7: When several triggers fire on the same cycle, exactly one pulse results. A completion strobe sampled on that same cycle is counted into the cleared counter as one.
- R8: Either limit can be written at any time. If the pending count already equals or exceeds a newly written nonzero count limit, a pulse appears two cycles after the write cycle.
- R9: The queues are independent. A strobe, request or limit for one queue never affects the pulse of another.
- R10: `wrAddr` is {queue index, select bit}. A select bit of 0 writes the count limit and 1 writes the tick limit. Limits are 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Limit register write enable |
| wrAddr | input | 3 | {queue index, select}; select 0 = count limit, 1 = tick limit |
| wrData | input | 8 | Limit value to write |
| cmplStb | input | 4 | Per-queue completion strobe, one completion per cycle high |
| extReq | input | 4 | Per-queue update request from other event sources |
| updPulse | output | 4 | Per-queue one-cycle update-issued pulse |

## Verification
The hardest case to reach is a cycle on which the count trigger, an external request and a new completion all fall together. The pulse must stay single, and the completion must survive the clear as a count of one. The stimulus reaches this by reaching one short of a count limit of two. It then raises the request and a strobe on exactly the cycle that the count trigger fires. Finally it sends one more strobe and expects a pulse, which can only come if the carried-over completion was kept. A second hard case is a limit lowered below an already accumulated count. This is reached by letting completions pile up with all triggers off, then writing the smaller limit.

// File: rtl/txc_pkg.sv
package txc_pkg;
  parameter int unsigned TXC_LIM_W = 8;

  // Strobes from a queue's control to its datapath
  typedef struct packed {
    logic clr;  // an update is issued this cycle: restart count and timer
    logic inc;  // a completion is counted this cycle
    logic run;  // completions are pending: let the timer advance
  } txcStrb_t;
endpackage

// File: rtl/txc_limit_regs.sv
module txc_limit_regs #(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned LIM_W = 8,
  localparam int unsigned QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned AW = QW + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AW-1:0]               wrAddr,
  input  logic [LIM_W-1:0]            wrData,
  output logic [NUM_Q-1:0][LIM_W-1:0] cntLim,
  output logic [NUM_Q-1:0][LIM_W-1:0] tickLim
);
  logic [QW-1:0] wrQ;
  logic          wrSel;

  assign wrQ   = wrAddr[AW-1:1];
  assign wrSel = wrAddr[0];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic hitQ;
    assign hitQ = wrEn && (wrQ == QW'(q));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntLim[q]  <= '0;
        tickLim[q] <= '0;
      end else if (hitQ) begin
        if (wrSel) tickLim[q] <= wrData;
        else       cntLim[q]  <= wrData;
      end
    end
  end
endmodule

// File: rtl/txc_queue_dp.sv
module txc_queue_dp
  import txc_pkg::*;
#(
  parameter int unsigned LIM_W = TXC_LIM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  txcStrb_t         strb,
  output logic [LIM_W-1:0] pendCnt,
  output logic [LIM_W-1:0] tickCnt
);
  localparam logic [LIM_W-1:0] MAXV = {LIM_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
      tickCnt <= '0;
    end else if (strb.clr) begin
      pendCnt <= strb.inc ? LIM_W'(1) : '0;
      tickCnt <= '0;
    end else begin
      if (strb.inc && pendCnt != MAXV) pendCnt <= pendCnt + 1'b1;
      if (!strb.run)            tickCnt <= '0;
      else if (tickCnt != MAXV) tickCnt <= tickCnt + 1'b1;
    end
  end

  // R2
  inc_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clr && strb.inc && pendCnt != MAXV) |=> pendCnt == $past(pendCnt) + 1'b1);

  // R6
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == '0) |-> (tickCnt == '0));
endmodule

// File: rtl/txc_queue_ctrl.sv
module txc_queue_ctrl
  import txc_pkg::*;
#(
  parameter int unsigned LIM_W = TXC_LIM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmplStb,
  input  logic             extReq,
  input  logic [LIM_W-1:0] cntLim,
  input  logic [LIM_W-1:0] tickLim,
  input  logic [LIM_W-1:0] pendCnt,
  input  logic [LIM_W-1:0] tickCnt,
  output txcStrb_t         strb,
  output logic             updPulse
);
  logic countHit, timerHit, fire;

  assign countHit = (cntLim != '0) && (pendCnt >= cntLim);
  assign timerHit = (tickLim != '0) && (pendCnt != '0) && (tickCnt >= tickLim);
  assign fire     = countHit || timerHit || extReq;

  always_comb begin
    strb.clr = fire;
    strb.inc = cmplStb;
    strb.run = (pendCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updPulse <= 1'b0;
    else       updPulse <= fire;
  end

  // R2
  count_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntLim != '0 && pendCnt >= cntLim) |=> updPulse);

  // R5
  ext_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    extReq |=> (updPulse && pendCnt <= LIM_W'(1)));

  // R7
  clear_after_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |-> (pendCnt <= LIM_W'(1) && tickCnt == '0));

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntLim == '0 && tickLim == '0 && !extReq) |=> !updPulse);

  // R6
  timer_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickLim != '0 && pendCnt != '0 && tickCnt >= tickLim) |=> updPulse);
endmodule

// File: rtl/txc_coalescer.sv
module txc_coalescer
  import txc_pkg::*;
#(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned LIM_W = TXC_LIM_W,
  localparam int unsigned QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned AW = QW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [LIM_W-1:0] wrData,
  input  logic [NUM_Q-1:0] cmplStb,
  input  logic [NUM_Q-1:0] extReq,
  output logic [NUM_Q-1:0] updPulse
);
  logic [NUM_Q-1:0][LIM_W-1:0] cntLim, tickLim;

  txc_limit_regs #(.NUM_Q(NUM_Q), .LIM_W(LIM_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntLim(cntLim), .tickLim(tickLim)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    txcStrb_t         strb;
    logic [LIM_W-1:0] pendCnt, tickCnt;

    txc_queue_ctrl #(.LIM_W(LIM_W)) u_ctrl (
      .clk(clk), .rstN(rstN), .cmplStb(cmplStb[q]), .extReq(extReq[q]),
      .cntLim(cntLim[q]), .tickLim(tickLim[q]),
      .pendCnt(pendCnt), .tickCnt(tickCnt),
      .strb(strb), .updPulse(updPulse[q])
    );

    txc_queue_dp #(.LIM_W(LIM_W)) u_dp (
      .clk(clk), .rstN(rstN), .strb(strb),
      .pendCnt(pendCnt), .tickCnt(tickCnt)
    );
  end
endmodule

// File: tb/txc_coalescer_bench.sv
module txc_coalescer_bench;
  localparam int NQ = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [NQ-1:0] cmplStb = '0;
  logic [NQ-1:0] extReq = '0;
  logic [NQ-1:0] updPulse;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  typedef struct {
    int    at;
    int    q;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  txc_coalescer u_txc_coalescer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmplStb(cmplStb), .extReq(extReq), .updPulse(updPulse)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every queue's pulse against the scoreboard each cycle
  always @(negedge clk) begin
    logic [NQ-1:0] expV;
    string         tag[NQ];
    expV = '0;
    for (int q = 0; q < NQ; q++) tag[q] = curReq;
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        expV[expQ[i].q] = 1'b1;
        tag[expQ[i].q]  = expQ[i].req;
        expQ.delete(i);
      end
    end
    for (int q = 0; q < NQ; q++) begin
      checks++;
      if (updPulse[q] !== expV[q]) begin
        errors++;
        $display("FAIL %s q%0d cycle %0d actual %b expected %b",
                 tag[q], q, cyc, updPulse[q], expV[q]);
      end
    end
  end

  task automatic expectPulse(int at, int q, string req);
    expItem_t it;
    it.at = at; it.q = q; it.req = req;
    expQ.push_back(it);
  endtask

  // One driven cycle; afterwards cyc names the cycle just driven
  task automatic drv(logic [NQ-1:0] c, logic [NQ-1:0] e);
    @(posedge clk); #1;
    wrEn = 1'b0; cmplStb = c; extReq = e;
  endtask

  task automatic wr(int q, int sel, int val);
    @(posedge clk); #1;
    cmplStb = '0; extReq = '0;
    wrEn = 1'b1; wrAddr = {q[1:0], sel[0]}; wrData = val[7:0];
  endtask

  task automatic idle(int n);
    repeat (n) drv('0, '0);
  endtask

  task automatic flush(int q, string req);
    drv('0, NQ'(1) << q);
    expectPulse(cyc + 1, q, req);
    idle(3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state, limits zero, no pulse
    idle(5);

    // R4: zero limits, many completions, no pulse
    curReq = "R4";
    for (int i = 0; i < 10; i++) drv(4'b0001, '0);
    idle(5);
    flush(0, "R5");

    // R3: limit one, pulse per completion
    curReq = "R3";
    wr(0, 0, 1); idle(2);
    for (int i = 0; i < 3; i++) begin
      drv(4'b0001, '0); expectPulse(cyc + 2, 0, "R3"); idle(3);
    end
    drv(4'b0001, '0); expectPulse(cyc + 2, 0, "R3");
    drv(4'b0001, '0); expectPulse(cyc + 2, 0, "R7");
    idle(4);

    // R2: limit four, spaced completions
    curReq = "R2";
    wr(0, 0, 4); idle(1);
    for (int i = 0; i < 4; i++) begin
      drv(4'b0001, '0);
      if (i == 3) expectPulse(cyc + 2, 0, "R2");
      idle(1);
    end
    idle(4);

    // R5: external request clears the pending count
    curReq = "R5";
    for (int i = 0; i < 2; i++) begin drv(4'b0001, '0); idle(1); end
    drv('0, 4'b0001); expectPulse(cyc + 1, 0, "R5");
    idle(2);
    for (int i = 0; i < 4; i++) begin
      drv(4'b0001, '0);
      if (i == 3) expectPulse(cyc + 2, 0, "R5");
      idle(1);
    end
    idle(4);

    // R7: count hit, external request and a new completion on one cycle
    curReq = "R7";
    wr(0, 0, 2); idle(1);
    drv(4'b0001, '0);
    drv(4'b0001, '0);
    drv(4'b0001, 4'b0001); expectPulse(cyc + 1, 0, "R7");
    idle(2);
    drv(4'b0001, '0); expectPulse(cyc + 2, 0, "R7");
    idle(4);

    // R8: lowering the limit below an accumulated count
    curReq = "R8";
    wr(0, 0, 0); idle(1);
    for (int i = 0; i < 5; i++) drv(4'b0001, '0);
    idle(2);
    wr(0, 0, 3); expectPulse(cyc + 2, 0, "R8");
    idle(4);

    // R6: tick timer with count trigger off
    curReq = "R6";
    wr(0, 0, 0); wr(0, 1, 5); idle(1);
    drv(4'b0001, '0); expectPulse(cyc + 7, 0, "R6");
    idle(12);
    drv(4'b0001, '0); expectPulse(cyc + 7, 0, "R6");
    idle(1);
    drv(4'b0001, '0);
    idle(12);
    wr(0, 1, 0); idle(1);
    drv(4'b0001, '0);
    idle(20);
    flush(0, "R6");

    // R9: independent queues
    curReq = "R9";
    wr(1, 0, 2); wr(2, 0, 1); wr(3, 1, 3); idle(1);
    drv(4'b0110, '0); expectPulse(cyc + 2, 2, "R9");
    drv(4'b0010, '0); expectPulse(cyc + 2, 1, "R9");
    idle(4);
    drv('0, 4'b0001); expectPulse(cyc + 1, 0, "R9");
    idle(3);

    // R10: select bit 1 wrote queue 3's tick limit
    curReq = "R10";
    drv(4'b1000, '0); expectPulse(cyc + 5, 3, "R10");
    idle(8);

    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 pending expectations actual %0d expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule